// File: doc/BRIEF.md
# 1-Wire ROM Command Layer

This block sits between a 1-Wire time-slot engine and a slave's memory-function logic. The slot engine reports bus resets, whole received bytes, single received bits and requests for the next bit to drive. After every bus reset the block takes exactly one network command byte. Depending on that byte, it streams out its 64-bit registration ID, compares an incoming ID bit by bit, skips addressing, or reselects itself through a kept resume flag. When the command completes in its favour, the block raises a grant that opens the memory-function layer.

The registration ID comes from parameters. The family code sits in the low byte and the serial number in the next 48 bits. The top byte holds a CRC-8 computed at elaboration over those 56 bits. The resume flag survives bus resets and is cleared only by the chip reset or by the commands that address the bus again.

Top module: `owr_rom_layer`

## Requirements
- R1: After chip reset (rst_n low), grant and rc_flag are 0 and tx_bit is 1.
- R2: The ID is streamed least significant bit first: bits 0..7 are the family code (default 2Dh), bits 8..55 the serial number, and bits 56..63 a CRC of bits 0..55 with polynomial x^8+x^5+x^4+1 (register starts at zero, data fed LSB first). Feeding all 64 bits through the same CRC yields zero.
- R3: Command byte 33h (read ID) makes tx_bit show ID bit n before the n-th tx_req pulse. The first tx_req advances from bit 0 to bit 1. One cycle after the 64th tx_req, grant and rc_flag are 1.
- R4: Command byte 55h (match ID) compares each rx_bit strobe with the next ID bit, starting at bit 0. One cycle after the 64th matching bit, grant and rc_flag are 1.
- R5: In match mode, one cycle after a bit that differs from the ID, rc_flag is 0 and grant stays 0. All further bits and bytes are ignored until a bus reset.
- R6: Command byte CCh (skip) sets grant to 1 and rc_flag to 0 one cycle after the byte strobe.
- R7: Command byte A5h (resume) sets grant to the current rc_flag one cycle after the strobe and leaves rc_flag unchanged. If rc_flag was 0, later bytes are ignored until a bus reset.
- R8: Any other command byte leaves grant at 0 and rc_flag unchanged, and the block ignores all later bytes until a bus reset.
- R9: One cycle after a bus_rst pulse, grant is 0, rc_flag holds its prior value, and the next byte is decoded as a command. A bus_rst pulse takes priority over any strobe in the same cycle.
- R10: Once granted, grant and rc_flag stay unchanged by further bytes, bits or tx_req pulses until bus_rst or chip reset.
- R11: tx_bit is 1 whenever the block is not streaming the ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset, clears rc_flag |
| bus_rst | input | 1 | One-cycle pulse: bus reset seen by slot layer |
| rx_byte_vld | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte, valid with strobe |
| rx_bit_vld | input | 1 | Received single bit strobe |
| rx_bit | input | 1 | Received bit value |
| tx_req | input | 1 | Slot layer consumed current tx_bit, advance |
| tx_bit | output | 1 | Bit to drive in the next read slot (1 = release) |
| grant | output | 1 | Memory-function layer may run |
| rc_flag | output | 1 | Resume flag |

## Verification
Grant and rc_flag are registers, so every command byte, match bit, final tx_req and bus reset shows its effect exactly one clock after the strobe. tx_bit is combinational from the bit counter, so it is valid in the same cycle as the current position and moves one clock after each tx_req. The bench drives each strobe for one cycle starting at a falling edge. It samples at the next falling edge, which falls right after the single registering edge. It reads each ID bit before issuing the request that consumes it.

// File: rtl/owr_rom_pkg.sv
package owr_rom_pkg;
  localparam int FAM_W = 8;
  localparam int SER_W = 48;
  localparam int CRC_W = 8;
  localparam int ID_W  = FAM_W + SER_W + CRC_W;

  localparam logic [7:0] OP_READ   = 8'h33;
  localparam logic [7:0] OP_MATCH  = 8'h55;
  localparam logic [7:0] OP_SKIP   = 8'hCC;
  localparam logic [7:0] OP_RESUME = 8'hA5;

  typedef enum logic [2:0] {
    RS_CMD, RS_SEND, RS_MATCH, RS_GRANT, RS_IDLE
  } rom_state_t;

  typedef enum logic [2:0] {
    CMD_READ, CMD_MATCH, CMD_SKIP, CMD_RESUME, CMD_BAD
  } rom_cmd_t;

  // one step of the x^8+x^5+x^4+1 shift register, data bit enters LSB side
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
    logic fb;
    fb = b ^ c[0];
    return {fb, c[7], c[6], c[5], c[4] ^ fb, c[3] ^ fb, c[2], c[1]};
  endfunction

  function automatic logic [CRC_W-1:0] crc8_calc(input logic [FAM_W+SER_W-1:0] d);
    logic [7:0] c;
    c = '0;
    for (int i = 0; i < FAM_W + SER_W; i++) c = crc8_step(c, d[i]);
    return c;
  endfunction
endpackage

// File: rtl/owr_cmd_decode.sv
module owr_cmd_decode
  import owr_rom_pkg::*;
(
  input  logic [7:0] code,
  output rom_cmd_t   cmd
);
  always_comb begin
    unique case (code)
      OP_READ:   cmd = CMD_READ;
      OP_MATCH:  cmd = CMD_MATCH;
      OP_SKIP:   cmd = CMD_SKIP;
      OP_RESUME: cmd = CMD_RESUME;
      default:   cmd = CMD_BAD;
    endcase
  end
endmodule

// File: rtl/owr_id_seq.sv
module owr_id_seq #(
  parameter int              ID_W   = 64,
  parameter logic [ID_W-1:0] ID_VAL = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic cur_bit,
  output logic at_last
);
  localparam int CW = $clog2(ID_W);
  localparam logic [CW-1:0] LAST = CW'(ID_W - 1);

  logic [CW-1:0] pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos <= '0;
    else if (clr)  pos <= '0;
    else if (adv)  pos <= (pos == LAST) ? '0 : pos + 1'b1;
  end

  assign cur_bit = ID_VAL[pos];
  assign at_last = (pos == LAST);
endmodule

// File: rtl/owr_rom_layer.sv
module owr_rom_layer
  import owr_rom_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY = 8'h2D,
  parameter logic [SER_W-1:0] SERIAL = 48'h00A1_B2C3_D4E5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       rx_byte_vld,
  input  logic [7:0] rx_byte,
  input  logic       rx_bit_vld,
  input  logic       rx_bit,
  input  logic       tx_req,
  output logic       tx_bit,
  output logic       grant,
  output logic       rc_flag
);
  localparam logic [CRC_W-1:0] CRC_VAL = crc8_calc({SERIAL, FAMILY});
  localparam logic [ID_W-1:0]  ID_VAL  = {CRC_VAL, SERIAL, FAMILY};

  rom_state_t state;
  rom_cmd_t   cmd;
  logic       cur_bit, at_last;

  owr_cmd_decode u_dec (.code(rx_byte), .cmd(cmd));

  // named events
  logic cmd_take, skip_take, resume_take, bad_take;
  logic send_adv, match_adv, read_done, match_done, bit_miss;
  assign cmd_take    = !bus_rst && state == RS_CMD && rx_byte_vld;
  assign skip_take   = cmd_take && cmd == CMD_SKIP;
  assign resume_take = cmd_take && cmd == CMD_RESUME;
  assign bad_take    = cmd_take && cmd == CMD_BAD;
  assign send_adv    = !bus_rst && state == RS_SEND && tx_req;
  assign match_adv   = !bus_rst && state == RS_MATCH && rx_bit_vld;
  assign bit_miss    = match_adv && (rx_bit != cur_bit);
  assign read_done   = send_adv && at_last;
  assign match_done  = match_adv && !bit_miss && at_last;

  owr_id_seq #(.ID_W(ID_W), .ID_VAL(ID_VAL)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .clr(bus_rst || state == RS_CMD),
    .adv(send_adv || match_adv),
    .cur_bit(cur_bit), .at_last(at_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RS_CMD; grant <= 1'b0; rc_flag <= 1'b0;
    end else if (bus_rst) begin
      state <= RS_CMD; grant <= 1'b0;
    end else begin
      unique case (state)
        RS_CMD: if (rx_byte_vld) begin
          unique case (cmd)
            CMD_READ:   state <= RS_SEND;
            CMD_MATCH:  state <= RS_MATCH;
            CMD_SKIP:   begin rc_flag <= 1'b0; grant <= 1'b1; state <= RS_GRANT; end
            CMD_RESUME: if (rc_flag) begin grant <= 1'b1; state <= RS_GRANT; end
                        else state <= RS_IDLE;
            default:    state <= RS_IDLE;
          endcase
        end
        RS_SEND: if (tx_req && at_last) begin
          rc_flag <= 1'b1; grant <= 1'b1; state <= RS_GRANT;
        end
        RS_MATCH: if (rx_bit_vld) begin
          if (rx_bit != cur_bit) begin
            rc_flag <= 1'b0; state <= RS_IDLE;
          end else if (at_last) begin
            rc_flag <= 1'b1; grant <= 1'b1; state <= RS_GRANT;
          end
        end
        default: ;
      endcase
    end
  end

  assign tx_bit = (state == RS_SEND) ? cur_bit : 1'b1;

  // R9
  bus_rst_keeps_rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (!grant && rc_flag == $past(rc_flag)));
  // R3 R4
  rc_set_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rc_flag) |-> $past(read_done || match_done));
  // R5
  miss_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_miss |=> (!rc_flag && !grant));
  // R6
  skip_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_take |=> (grant && !rc_flag));
  // R7
  resume_follows_rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_take |=> (grant == $past(rc_flag) && rc_flag == $past(rc_flag)));
  // R8
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_take |=> (!grant && rc_flag == $past(rc_flag)));
  // R10
  grant_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !bus_rst) |=> (grant && $stable(rc_flag)));
  // R11
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || state == RS_IDLE) |-> tx_bit);
endmodule

// File: tb/owr_rom_layer_bench.sv
module owr_rom_layer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  FAM = 8'h2D;
  localparam logic [47:0] SER = 48'h00A1_B2C3_D4E5;

  logic clk = 1'b0, rst_n = 1'b0, bus_rst = 1'b0;
  logic rx_byte_vld = 1'b0, rx_bit_vld = 1'b0, rx_bit = 1'b0, tx_req = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic tx_bit, grant, rc_flag;

  int tests = 0, fails = 0, cyc = 0;
  logic m_rc = 1'b0;
  logic [63:0] exp_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  owr_rom_layer u_owr_rom_layer (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
    .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
    .rx_bit_vld(rx_bit_vld), .rx_bit(rx_bit), .tx_req(tx_req),
    .tx_bit(tx_bit), .grant(grant), .rc_flag(rc_flag));

  // table-free reflected CRC: xor 8Ch when the outgoing bit differs
  function automatic logic [7:0] ref_crc(input logic [63:0] d, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ 8'h8C;
      else             c = c >> 1;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic send_byte(input logic [7:0] b);
    rx_byte = b; rx_byte_vld = 1'b1; tick(); rx_byte_vld = 1'b0;
  endtask
  task automatic send_bit(input logic b);
    rx_bit = b; rx_bit_vld = 1'b1; tick(); rx_bit_vld = 1'b0;
  endtask
  task automatic do_bus_rst();
    bus_rst = 1'b1; tick(); bus_rst = 1'b0;
  endtask
  task automatic read_id(output logic [63:0] got);
    for (int i = 0; i < 64; i++) begin
      got[i] = tx_bit; tx_req = 1'b1; tick(); tx_req = 1'b0;
    end
  endtask
  task automatic match_id(input int miss_at);
    for (int i = 0; i < 64; i++) send_bit(exp_id[i] ^ (i == miss_at));
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] got;
    exp_id = {ref_crc({8'h00, SER, FAM}, 56), SER, FAM};
    void'($urandom(32'd7321));
    tick(); tick();
    chk("R1 grant", grant, 0); chk("R1 rc", rc_flag, 0); chk("R1 tx_bit", tx_bit, 1);
    rst_n = 1'b1; tick();

    // resume with rc clear, then ignored
    send_byte(8'hA5); chk("R7 resume rc0", grant, 0);
    send_byte(8'hCC); chk("R7 idle after resume", grant, 0);
    do_bus_rst();

    // read ID
    send_byte(8'h33); read_id(got);
    chk("R2 family", got[7:0], 8'h2D);
    chk("R2 crc byte", got[63:56], ref_crc(got, 56));
    chk("R2 crc residue", ref_crc(got, 64), 0);
    chk("R3 id", got, exp_id);
    chk("R3 grant", grant, 1); chk("R3 rc", rc_flag, 1);
    chk("R11 tx idle", tx_bit, 1);
    send_byte(8'hCC); chk("R10 rc kept", rc_flag, 1); chk("R10 grant kept", grant, 1);
    do_bus_rst(); chk("R9 grant", grant, 0); chk("R9 rc", rc_flag, 1);
    send_byte(8'hA5); chk("R7 resume grant", grant, 1); chk("R7 rc", rc_flag, 1);
    do_bus_rst();
    send_byte(8'hCC); chk("R6 grant", grant, 1); chk("R6 rc", rc_flag, 0);
    do_bus_rst();
    send_byte(8'h55); match_id(-1); chk("R4 grant", grant, 1); chk("R4 rc", rc_flag, 1);
    do_bus_rst();
    send_byte(8'h55); send_bit(~exp_id[0]);
    chk("R5 miss bit0 rc", rc_flag, 0); chk("R5 grant", grant, 0);
    for (int i = 1; i < 64; i++) send_bit(exp_id[i]);
    send_byte(8'hCC); chk("R5 ignored after miss", grant, 0);
    do_bus_rst(); send_byte(8'hCC); do_bus_rst();
    send_byte(8'h55); match_id(63); chk("R5 miss bit63", {grant, rc_flag}, 2'b00);
    do_bus_rst();
    send_byte(8'h00); chk("R8 bad grant", grant, 0);
    send_byte(8'hCC); chk("R8 ignored", grant, 0); chk("R8 rc", rc_flag, 0);
    // bus reset beats strobe in same cycle
    bus_rst = 1'b1; rx_byte = 8'hCC; rx_byte_vld = 1'b1; tick();
    bus_rst = 1'b0; rx_byte_vld = 1'b0;
    chk("R9 priority", grant, 0);
    m_rc = 1'b0;

    for (int it = 0; it < 60; it++) begin
      int sel = $urandom % 5;
      logic [7:0] bad;
      case (sel)
        0: begin send_byte(8'h33); read_id(got); chk("R3 rand id", got, exp_id);
                 m_rc = 1; chk("R3 rand", {grant, rc_flag}, {1'b1, m_rc}); end
        1: begin send_byte(8'h55);
                 if ($urandom % 2) begin match_id(-1); m_rc = 1;
                   chk("R4 rand", {grant, rc_flag}, {1'b1, m_rc}); end
                 else begin match_id($urandom % 64); m_rc = 0;
                   chk("R5 rand", {grant, rc_flag}, {1'b0, m_rc}); end
           end
        2: begin send_byte(8'hCC); m_rc = 0;
                 chk("R6 rand", {grant, rc_flag}, {1'b1, m_rc}); end
        3: begin send_byte(8'hA5);
                 chk("R7 rand", {grant, rc_flag}, {m_rc, m_rc}); end
        default: begin
                 do bad = 8'($urandom);
                 while (bad == 8'h33 || bad == 8'h55 || bad == 8'hCC || bad == 8'hA5);
                 send_byte(bad); chk("R8 rand", {grant, rc_flag}, {1'b0, m_rc}); end
      endcase
      if ($urandom % 2) begin
        logic g = grant;
        send_byte(8'hCC);
        chk("R10 R8 R7 R5 rand extra", {grant, rc_flag}, {g, m_rc});
      end
      do_bus_rst(); chk("R9 rand", {grant, rc_flag}, {1'b0, m_rc});
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule